// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of every line of one small direct-mapped, write-back private cache. The cache sits on a shared snoop bus that carries one transaction at a time. The block takes blocking load and store requests from the CPU. From them it decides, per line, whether a bus transaction is needed. When one is, it requests the bus, waits for the grant and presents exactly one command: line read, read-for-ownership, invalidate or writeback. The memory side ends each command with a completion pulse.

It also watches the commands that other caches place on the bus. It answers a snooped command in the same cycle on two wired lines, one saying "copy held here" and one saying "this cache supplies dirty data". It then downgrades or drops its own copy. A clean-exclusive state lets a private line that is read and then written cost a single bus transaction. A dirty line leaves the cache only on eviction or when another cache's miss snoops it.

The data array, the bus arbiter and the memory are outside the block. Only their handshakes appear at the ports.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is Invalid. The CPU side is ready, no bus request is raised, a snooped read of any address raises neither response line, and the first CPU read of any address issues a bus read.
- R2: A CPU read that misses issues one bus read (command code 0) for the requested address. The line fills to clean-exclusive if bus_shared_in is low in the completion cycle, and to Shared if it is high.
- R3: A CPU write to a clean-exclusive line completes with no bus request and leaves the line Modified.
- R4: A CPU write to a Shared line issues an invalidate (code 2) for that address and leaves the line Modified.
- R5: A CPU write that misses issues a read-for-ownership (code 1) and fills the line Modified.
- R6: A miss whose victim line is Modified first issues a writeback (code 3) carrying the victim's address. The line is then Invalid, and the fill command for the new address follows.
- R7: A snooped read (code 0) that hits a Modified line raises both the flush and the shared response and leaves the line Shared. A snooped read that hits a Shared line raises only shared.
- R8: A snooped read that hits a clean-exclusive line raises shared without flush and leaves the line Shared.
- R9: A snooped read-for-ownership or invalidate that hits a valid line leaves it Invalid, raising flush only if it was Modified. Snoops whose tag does not match, and snooped writebacks, change nothing and raise no response.
- R10: A bus command is presented only in the cycle after a grant, and it holds its code and address until the completion pulse.
- R11: Snoops take priority over the CPU. A snoop that arrives while this cache awaits a grant makes the controller re-decide its command from the updated line state, and the state array is never written by both sources in one cycle.
- R12: The CPU side is blocking: ready drops for the cycle after a request is accepted and stays low until completion, which is a single-cycle done pulse.
- R13: A CPU read that hits any valid line completes without a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_req_ready | output | 1 | Controller idle, request is taken this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Arbitration request, held through the transfer |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd_valid | output | 1 | Own bus command presented |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_cmd_addr | output | ADDR_W | Line address of the own command |
| bus_done | input | 1 | Completion of the own command |
| bus_shared_in | input | 1 | Another cache holds the line, valid with bus_done |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command code, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Copy held here (response to snooped read) |
| snp_flush | output | 1 | This cache supplies its dirty line |

## Verification
The hardest case to reach is a snoop that lands while the controller holds a decided command but has not yet been granted the bus. The snoop makes that command stale, for instance an invalidate of a line another cache has just taken. The bench gets there by holding the grant back from its arbiter model. While the store waits in arbitration, it injects a read-for-ownership snoop for the same line and only then releases the grant. The scoreboard expects a read-for-ownership rather than the invalidate. The state of a line is never read directly. It is inferred at the ports, from whether a later store needs the bus and from which response lines a later snooped read raises.

// File: rtl/mesi_pkg.sv
// Shared types of the coherence controller: per-line state and bus command codes.
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_INV = 2'd2,
        BC_WB  = 2'd3
    } bus_op_t;
endpackage

// File: rtl/mesi_line_store.sv
// Per-line state and tag storage of the direct-mapped cache.
// Two combinational read ports (request side and snoop side) and one
// synchronous write port. Assumes the caller resolves write priority.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_t         a_st,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_t         b_st,
    output logic [TAG_W-1:0] b_tag,
    input  logic             w_en,
    input  logic [IDX_W-1:0] w_idx,
    input  line_st_t         w_st,
    input  logic [TAG_W-1:0] w_tag
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    // Reset every line to Invalid; otherwise apply the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LS_I;
                tag_q[i] <= '0;
            end
        end else if (w_en) begin
            st_q[w_idx]  <= w_st;
            tag_q[w_idx] <= w_tag;
        end
    end

    // Combinational read ports.
    always_comb begin
        a_st  = st_q[a_idx];
        a_tag = tag_q[a_idx];
        b_st  = st_q[b_idx];
        b_tag = tag_q[b_idx];
    end
endmodule

// File: rtl/mesi_snoop_resp.sv
// Snoop decoder: given a snooped command and the addressed line, produces the
// same-cycle shared/flush responses and the line's next state.
// Assumes snoops are seen only while another cache owns the bus.
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             resp_shared,
    output logic             resp_flush,
    output logic             upd_en,
    output line_st_t         upd_st
);
    logic    hit;
    bus_op_t op;

    // Tag match on a valid line.
    assign hit = snp_valid && (line_st != LS_I) && (line_tag == snp_tag);
    assign op  = bus_op_t'(snp_cmd);

    // Response and downgrade per snooped command.
    always_comb begin
        resp_shared = 1'b0;
        resp_flush  = 1'b0;
        upd_en      = 1'b0;
        upd_st      = LS_I;
        case (op)
            BC_RD: begin
                resp_shared = hit;
                resp_flush  = hit && (line_st == LS_M);
                upd_en      = hit && (line_st != LS_S);
                upd_st      = LS_S;
            end
            BC_RDX, BC_INV: begin
                resp_flush  = hit && (line_st == LS_M);
                upd_en      = hit;
                upd_st      = LS_I;
            end
            default: begin
                upd_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mesi_req_fsm.sv
// CPU-side controller: accepts one blocking request, looks up the line,
// decides on a bus command, arbitrates, transfers and updates the line.
// Assumes an atomic bus: no snoop is seen while this cache owns the bus.
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    input  logic              snp_busy,
    output logic [IDX_W-1:0]  look_idx,
    input  line_st_t          look_st,
    input  logic [ADDR_W-IDX_W-1:0] look_tag,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    output logic              w_en,
    output logic [IDX_W-1:0]  w_idx,
    output line_st_t          w_st,
    output logic [ADDR_W-IDX_W-1:0] w_tag
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic [1:0] {F_IDLE, F_LOOK, F_ARB, F_XFER} fsm_t;

    fsm_t              fs, fs_n;
    logic [ADDR_W-1:0] r_addr;
    logic              r_we;
    bus_op_t           r_op, op_n;
    logic [ADDR_W-1:0] r_caddr, caddr_n;
    logic              r_done, done_n;
    logic [TAG_W-1:0]  req_tag;
    logic              hit;

    assign req_tag  = r_addr[ADDR_W-1:IDX_W];
    assign look_idx = r_addr[IDX_W-1:0];
    assign hit      = (look_st != LS_I) && (look_tag == req_tag);

    // Next state, command choice and line updates.
    always_comb begin
        fs_n    = fs;
        op_n    = r_op;
        caddr_n = r_caddr;
        done_n  = 1'b0;
        w_en    = 1'b0;
        w_idx   = look_idx;
        w_st    = LS_I;
        w_tag   = req_tag;
        case (fs)
            F_IDLE: begin
                if (cpu_req_valid) fs_n = F_LOOK;
            end
            F_LOOK: begin
                if (!snp_busy) begin
                    if (hit && (!r_we || look_st == LS_M)) begin
                        done_n = 1'b1;
                        fs_n   = F_IDLE;
                    end else if (hit && look_st == LS_E) begin
                        w_en   = 1'b1;
                        w_st   = LS_M;
                        done_n = 1'b1;
                        fs_n   = F_IDLE;
                    end else if (hit) begin
                        op_n    = BC_INV;
                        caddr_n = r_addr;
                        fs_n    = F_ARB;
                    end else if (look_st == LS_M) begin
                        op_n    = BC_WB;
                        caddr_n = {look_tag, look_idx};
                        fs_n    = F_ARB;
                    end else begin
                        op_n    = r_we ? BC_RDX : BC_RD;
                        caddr_n = r_addr;
                        fs_n    = F_ARB;
                    end
                end
            end
            F_ARB: begin
                if (snp_busy)     fs_n = F_LOOK;
                else if (bus_gnt) fs_n = F_XFER;
            end
            F_XFER: begin
                if (bus_done) begin
                    w_en = 1'b1;
                    case (r_op)
                        BC_WB: begin
                            w_st  = LS_I;
                            w_tag = look_tag;
                            fs_n  = F_LOOK;
                        end
                        BC_RD: begin
                            w_st   = bus_shared_in ? LS_S : LS_E;
                            done_n = 1'b1;
                            fs_n   = F_IDLE;
                        end
                        default: begin
                            w_st   = LS_M;
                            done_n = 1'b1;
                            fs_n   = F_IDLE;
                        end
                    endcase
                end
            end
            default: fs_n = F_IDLE;
        endcase
    end

    // State, latched request and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs      <= F_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_op    <= BC_RD;
            r_caddr <= '0;
            r_done  <= 1'b0;
        end else begin
            fs      <= fs_n;
            r_op    <= op_n;
            r_caddr <= caddr_n;
            r_done  <= done_n;
            if (fs == F_IDLE && cpu_req_valid) begin
                r_addr <= cpu_req_addr;
                r_we   <= cpu_req_we;
            end
        end
    end

    assign cpu_req_ready = (fs == F_IDLE);
    assign cpu_done      = r_done;
    assign bus_req       = (fs == F_ARB) || (fs == F_XFER);
    assign bus_cmd_valid = (fs == F_XFER);
    assign bus_cmd       = r_op;
    assign bus_cmd_addr  = r_caddr;

    // R10: a command only follows a grant.
    p_gnt_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cmd_valid) |-> $past(bus_gnt));

    // R10: command code and address hold until completion.
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && !bus_done) |=> (bus_cmd_valid && $stable(bus_cmd) && $stable(bus_cmd_addr)));

    // R12: an accepted request blocks the CPU side.
    p_blocking_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R12: completion is a single-cycle pulse.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R11: a snoop during arbitration withdraws the pending command.
    p_snoop_yield_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_busy && bus_req && !bus_cmd_valid) |=> !bus_cmd_valid);

    // R6: a writeback never completes the CPU request by itself.
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_done && bus_cmd == BC_WB) |=> (!cpu_done && !cpu_req_ready));
endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the snooping MESI controller for a direct-mapped write-back cache.
// Joins the line store, the snoop decoder and the request controller, and
// arbitrates the single state-write port with snoop updates first.
// Assumes snp_valid is raised only while another cache owns the bus.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    input  logic              bus_done,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] look_idx;
    line_st_t         look_st, snp_st;
    logic [TAG_W-1:0] look_tag, snp_ltag;
    logic             f_w_en, s_w_en;
    logic [IDX_W-1:0] f_w_idx;
    line_st_t         f_w_st, s_w_st;
    logic [TAG_W-1:0] f_w_tag;
    logic             m_w_en;
    logic [IDX_W-1:0] m_w_idx;
    line_st_t         m_w_st;
    logic [TAG_W-1:0] m_w_tag;

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .a_idx (look_idx),
        .a_st  (look_st),
        .a_tag (look_tag),
        .b_idx (snp_addr[IDX_W-1:0]),
        .b_st  (snp_st),
        .b_tag (snp_ltag),
        .w_en  (m_w_en),
        .w_idx (m_w_idx),
        .w_st  (m_w_st),
        .w_tag (m_w_tag)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_tag     (snp_addr[ADDR_W-1:IDX_W]),
        .line_st     (snp_st),
        .line_tag    (snp_ltag),
        .resp_shared (snp_shared),
        .resp_flush  (snp_flush),
        .upd_en      (s_w_en),
        .upd_st      (s_w_st)
    );

    mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_we    (cpu_req_we),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_ready (cpu_req_ready),
        .cpu_done      (cpu_done),
        .snp_busy      (snp_valid),
        .look_idx      (look_idx),
        .look_st       (look_st),
        .look_tag      (look_tag),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd       (bus_cmd),
        .bus_cmd_addr  (bus_cmd_addr),
        .bus_done      (bus_done),
        .bus_shared_in (bus_shared_in),
        .w_en          (f_w_en),
        .w_idx         (f_w_idx),
        .w_st          (f_w_st),
        .w_tag         (f_w_tag)
    );

    // Write-port arbitration: snoop updates win.
    always_comb begin
        m_w_en = s_w_en || f_w_en;
        if (s_w_en) begin
            m_w_idx = snp_addr[IDX_W-1:0];
            m_w_st  = s_w_st;
            m_w_tag = snp_ltag;
        end else begin
            m_w_idx = f_w_idx;
            m_w_st  = f_w_st;
            m_w_tag = f_w_tag;
        end
    end

    // R11: snoop and request side never update the array together.
    p_one_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_w_en && f_w_en));

    // R9: responses appear only for a snooped command.
    p_resp_needs_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush || snp_shared) |-> snp_valid);

    // R10: no snoop is answered while this cache drives a command.
    p_atomic_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> !snp_valid);
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_req_ready, cpu_done;
    logic          bus_req, bus_cmd_valid;
    logic          bus_gnt = 1'b0, bus_done = 1'b0, bus_shared_in = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_cmd_addr;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_flush;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic          sh;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic gnt_en = 1'b1;

    always #4 clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd),
        .bus_cmd_addr(bus_cmd_addr), .bus_done(bus_done),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic sh);
        exp_t e;
        e.op = op; e.addr = a; e.sh = sh;
        exp_q.push_back(e);
    endtask

    // Arbiter and memory model; monitor pops and compares bus commands.
    initial begin
        bit busy = 0;
        int cnt = 0;
        logic last_gnt = 0;
        exp_t cur;
        cur = '0;
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            bus_shared_in = 1'b0;
            if (bus_cmd_valid) begin
                if (!busy) begin
                    busy = 1; cnt = 0;
                    chk(last_gnt, "R10", "command without prior grant", 0, 1);
                    if (exp_q.size() == 0) begin
                        chk(0, "R3/R13", "unexpected bus command", int'(bus_cmd), 0);
                        cur.op = bus_cmd; cur.addr = bus_cmd_addr; cur.sh = 0;
                    end else begin
                        cur = exp_q.pop_front();
                        chk(bus_cmd == cur.op, "R2/R4/R5/R6/R11", "bus command code",
                            int'(bus_cmd), int'(cur.op));
                        chk(bus_cmd_addr == cur.addr, "R2/R4/R5/R6/R11", "bus command address",
                            int'(bus_cmd_addr), int'(cur.addr));
                    end
                end else begin
                    cnt++;
                    if (cnt == 2) begin
                        bus_done = 1'b1;
                        bus_shared_in = cur.sh;
                        busy = 0;
                    end
                end
            end
            bus_gnt = bus_req && gnt_en;
            last_gnt = bus_gnt;
        end
    end

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input string req);
        int guard;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(!cpu_req_ready, "R12", "ready after accept", int'(cpu_req_ready), 0);
        guard = 0;
        while (!cpu_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(cpu_done, req, "completion seen", int'(cpu_done), 1);
        @(negedge clk);
        chk(!cpu_done, "R12", "done is one cycle", int'(cpu_done), 0);
        chk(exp_q.size() == 0, req, "expected commands left", exp_q.size(), 0);
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic sh, input logic fl, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = op; snp_addr = a;
        #1;
        chk(snp_shared == sh, req, "snoop shared", int'(snp_shared), int'(sh));
        chk(snp_flush == fl, req, "snoop flush", int'(snp_flush), int'(fl));
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_req_ready, "R1", "ready after reset", int'(cpu_req_ready), 1);
        chk(!bus_req, "R1", "bus_req after reset", int'(bus_req), 0);
        chk(!cpu_done, "R1", "done after reset", int'(cpu_done), 0);
        snoop(2'd0, 12'h010, 0, 0, "R1");
        // R2: read miss, no sharer -> E; R13 read hit
        expect_cmd(2'd0, 12'h010, 0);
        cpu_op(0, 12'h010, "R2");
        cpu_op(0, 12'h010, "R13");
        // R3: write to E silent
        cpu_op(1, 12'h010, "R3");
        // R7: snooped read of M flushes, then S only shares
        snoop(2'd0, 12'h010, 1, 1, "R7");
        snoop(2'd0, 12'h010, 1, 0, "R7");
        // R4: write to S invalidates
        expect_cmd(2'd2, 12'h010, 0);
        cpu_op(1, 12'h010, "R4");
        // R9: snooped read-for-ownership of M flushes and drops
        snoop(2'd1, 12'h010, 0, 1, "R9");
        snoop(2'd0, 12'h010, 0, 0, "R9");
        expect_cmd(2'd0, 12'h010, 0);
        cpu_op(0, 12'h010, "R9");
        // R2: read miss with sharer -> S, so a write needs invalidate
        expect_cmd(2'd0, 12'h011, 1);
        cpu_op(0, 12'h011, "R2");
        expect_cmd(2'd2, 12'h011, 0);
        cpu_op(1, 12'h011, "R2");
        // R8: snooped read of E shares without flush, line becomes S
        expect_cmd(2'd0, 12'h012, 0);
        cpu_op(0, 12'h012, "R8");
        snoop(2'd0, 12'h012, 1, 0, "R8");
        expect_cmd(2'd2, 12'h012, 0);
        cpu_op(1, 12'h012, "R8");
        // R5: write miss -> read-for-ownership, line M
        expect_cmd(2'd1, 12'h014, 0);
        cpu_op(1, 12'h014, "R5");
        cpu_op(1, 12'h014, "R5");
        // R6: dirty victim written back before the fill
        expect_cmd(2'd3, 12'h014, 0);
        expect_cmd(2'd0, 12'h024, 0);
        cpu_op(0, 12'h024, "R6");
        snoop(2'd0, 12'h014, 0, 0, "R6");
        // R9: tag mismatch and snooped writeback ignored; line stays E
        snoop(2'd1, 12'h034, 0, 0, "R9");
        snoop(2'd3, 12'h024, 0, 0, "R9");
        cpu_op(1, 12'h024, "R9");
        // R9: invalidate snoop on clean line drops it
        expect_cmd(2'd0, 12'h015, 0);
        cpu_op(0, 12'h015, "R9");
        snoop(2'd2, 12'h015, 0, 0, "R9");
        expect_cmd(2'd0, 12'h015, 0);
        cpu_op(0, 12'h015, "R9");
        // R11: snoop during arbitration turns a pending invalidate into RDX
        expect_cmd(2'd0, 12'h016, 1);
        cpu_op(0, 12'h016, "R11");
        gnt_en = 1'b0;
        expect_cmd(2'd1, 12'h016, 0);
        fork
            cpu_op(1, 12'h016, "R11");
            begin
                repeat (4) @(negedge clk);
                chk(bus_req && !bus_cmd_valid, "R11", "waiting for grant",
                    int'(bus_req), 1);
                snoop(2'd1, 12'h016, 0, 0, "R11");
                gnt_en = 1'b1;
            end
        join
        snoop(2'd0, 12'h016, 1, 1, "R11");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule